// File: doc/BRIEF.md
# Per-Bit Edge Event Detector

This block watches a monitor data bus of up to 256 bits and reports, for every bit separately, whether that bit made the kind of transition it has been set up to look for. Each bit owns a 2-bit edge-type code and an enable bit. Together they decide whether a rise, a fall or either change of that bit counts as an event. The block compares each new sample against the previous accepted sample. Samples are accepted only on cycles where the valid strobe is high.

Configuration goes through a small indexed port. A first write selects a detector number. Later writes carry either an edge-type code or an enable bit for the selected detector. Configuration can be read back as 32-bit words: edge-type codes are packed sixteen per word and enable bits thirty-two per word. The outputs are a registered event vector, one bit per monitored bit, and a flag that is the OR of that vector.

Top module: `bitwise_edge_monitor`

## Requirements
- R1: A detector with code 00 reports an event when its bit is 0 in the previous accepted sample and 1 in the current one.
- R2: A detector with code 01 reports an event when its bit goes from 1 in the previous accepted sample to 0 in the current one.
- R3: A detector with code 10 reports an event on any change of its bit between consecutive accepted samples.
- R4: A detector with code 11 never reports an event.
- R5: Enable bit 1 arms a detector. A detector whose enable bit is 0 never reports an event. After reset every enable bit is 0 and every code is 00.
- R6: Only cycles with mon_valid high are compared or stored as the previous sample. A cycle with mon_valid low yields an all-zero event vector in the next cycle and does not change the stored previous sample.
- R7: The first accepted sample after reset produces no event.
- R8: Events are registered. The event for the sample accepted at clock edge t is visible after edge t and lasts one cycle. evt_any equals the OR of evt_vec in that same cycle.
- R9: A write with cfg_idx_we loads the detector index. Each later cfg_val_we writes cfg_val[1:0] as the code (cfg_val_is_mask=0) or cfg_val[0] as the enable bit (cfg_val_is_mask=1) of that detector. The index is kept across value writes.
- R10: An index of NBITS (256) or more is not taken. It invalidates the held index, and value writes are discarded until a valid index is written.
- R11: Readback with rd_is_mask=0 returns code word rd_sel, where bits [2k+1:2k] hold detector 16*rd_sel+k. With rd_is_mask=1 it returns enable word rd_sel, where bit k holds detector 32*rd_sel+k. An enable word number of NBITS/32 or more reads as 0.
- R12: During and right after reset, evt_vec and evt_any are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_data | input | NBITS | Monitored data bus |
| mon_valid | input | 1 | Sample-valid strobe for mon_data |
| cfg_idx_we | input | 1 | Load detector index |
| cfg_idx | input | IDXW | Detector index |
| cfg_val_we | input | 1 | Write value to selected detector |
| cfg_val_is_mask | input | 1 | 1: value is the enable bit, 0: value is the edge code |
| cfg_val | input | 2 | Edge code, or enable bit in bit 0 |
| rd_sel | input | RSW | Readback word number |
| rd_is_mask | input | 1 | 1: read enable words, 0: read code words |
| rd_word | output | 32 | Readback word |
| evt_vec | output | NBITS | Registered per-bit event vector |
| evt_any | output | 1 | OR of evt_vec |

## Verification
The assertions assume that an index write and a value write never fall in the same cycle. In that case the value write would use the index held before that cycle. The discard check relies on this, and the bench always issues the two writes in separate cycles. The assertions also take mon_valid and the configuration strobes to be low during reset. The bench holds every input low until reset is released, and it changes inputs only on falling edges.

// File: rtl/edge_mon_pkg.sv
package edge_mon_pkg;

  localparam int WORD_W        = 32;
  localparam int CODES_PER_WORD = 16;
  localparam int ENAS_PER_WORD  = 32;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_ANY  = 2'b10,
    EDGE_OFF  = 2'b11
  } edge_code_e;

  function automatic logic edge_hit(input edge_code_e code, input logic prev, input logic cur);
    logic hit;
    case (code)
      EDGE_RISE: hit = ~prev & cur;
      EDGE_FALL: hit = prev & ~cur;
      EDGE_ANY:  hit = prev ^ cur;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/edge_cfg_bank.sv
module edge_cfg_bank #(
  parameter int NBITS = 256,
  parameter int IDXW  = $clog2(NBITS) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idx_we,
  input  logic [IDXW-1:0]    idx,
  input  logic               val_we,
  input  logic               val_is_mask,
  input  logic [1:0]         val,
  output logic [2*NBITS-1:0] code_flat,
  output logic [NBITS-1:0]   ena_q,
  output logic               idx_ok
);

  localparam int SELW = $clog2(NBITS);

  logic [SELW-1:0]    sel_q, sel_n;
  logic               ok_q, ok_n;
  logic [2*NBITS-1:0] code_q, code_n;
  logic [NBITS-1:0]   ena_n;
  logic               idx_en, code_en, ena_en;

  // index register next state
  always_comb begin
    sel_n = sel_q;
    ok_n  = ok_q;
    if (idx_we) begin
      if (idx < IDXW'(NBITS)) begin
        ok_n  = 1'b1;
        sel_n = idx[SELW-1:0];
      end else begin
        ok_n  = 1'b0;
      end
    end
  end

  assign idx_en  = idx_we;
  assign code_en = val_we & ok_q & ~val_is_mask;
  assign ena_en  = val_we & ok_q & val_is_mask;

  // storage next state
  always_comb begin
    code_n = code_q;
    ena_n  = ena_q;
    if (code_en) code_n[{sel_q, 1'b0} +: 2] = val;
    if (ena_en)  ena_n[sel_q] = val[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      ok_q  <= 1'b0;
    end else if (idx_en) begin
      sel_q <= sel_n;
      ok_q  <= ok_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (code_en) begin
      code_q <= code_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
    end else if (ena_en) begin
      ena_q <= ena_n;
    end
  end

  assign code_flat = code_q;
  assign idx_ok    = ok_q;

endmodule

// File: rtl/edge_readback.sv
module edge_readback
  import edge_mon_pkg::*;
#(
  parameter int NBITS = 256,
  parameter int RSW   = $clog2(NBITS / CODES_PER_WORD)
) (
  input  logic [2*NBITS-1:0] code_flat,
  input  logic [NBITS-1:0]   ena_q,
  input  logic [RSW-1:0]     rd_sel,
  input  logic               rd_is_mask,
  output logic [WORD_W-1:0]  rd_word
);

  localparam int NCW = NBITS / CODES_PER_WORD;
  localparam int NEW = NBITS / ENAS_PER_WORD;

  logic [WORD_W-1:0] code_word, ena_word;

  always_comb begin
    code_word = '0;
    for (int w = 0; w < NCW; w++) begin
      if (rd_sel == RSW'(w)) code_word = code_flat[w*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    ena_word = '0;
    for (int w = 0; w < NEW; w++) begin
      if (rd_sel == RSW'(w)) ena_word = ena_q[w*WORD_W +: WORD_W];
    end
  end

  assign rd_word = rd_is_mask ? ena_word : code_word;

endmodule

// File: rtl/edge_lane_array.sv
module edge_lane_array
  import edge_mon_pkg::*;
#(
  parameter int NBITS = 256
) (
  input  logic [2*NBITS-1:0] code_flat,
  input  logic [NBITS-1:0]   ena_q,
  input  logic [NBITS-1:0]   prev_q,
  input  logic [NBITS-1:0]   cur,
  output logic [NBITS-1:0]   hit
);

  for (genvar i = 0; i < NBITS; i++) begin : g_lane
    edge_code_e code_i;
    assign code_i = edge_code_e'(code_flat[2*i +: 2]);
    assign hit[i] = ena_q[i] & edge_hit(code_i, prev_q[i], cur[i]);
  end

endmodule

// File: rtl/edge_sample_reg.sv
module edge_sample_reg #(
  parameter int NBITS = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [NBITS-1:0] data,
  input  logic [NBITS-1:0] hit,
  output logic [NBITS-1:0] prev_q,
  output logic [NBITS-1:0] evt_q
);

  logic             primed_q, primed_n;
  logic [NBITS-1:0] evt_n, prev_n;
  logic             prev_en, primed_en;

  always_comb begin
    evt_n     = (valid && primed_q) ? hit : '0;
    prev_n    = data;
    primed_n  = 1'b1;
    prev_en   = valid;
    primed_en = valid & ~primed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= '0;
    else if (prev_en) prev_q <= prev_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         primed_q <= 1'b0;
    else if (primed_en) primed_q <= primed_n;
  end

endmodule

// File: rtl/bitwise_edge_monitor.sv
module bitwise_edge_monitor
  import edge_mon_pkg::*;
#(
  parameter int NBITS = 256,
  parameter int IDXW  = $clog2(NBITS) + 1,
  parameter int RSW   = $clog2(NBITS / CODES_PER_WORD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBITS-1:0]  mon_data,
  input  logic              mon_valid,
  input  logic              cfg_idx_we,
  input  logic [IDXW-1:0]   cfg_idx,
  input  logic              cfg_val_we,
  input  logic              cfg_val_is_mask,
  input  logic [1:0]        cfg_val,
  input  logic [RSW-1:0]    rd_sel,
  input  logic              rd_is_mask,
  output logic [WORD_W-1:0] rd_word,
  output logic [NBITS-1:0]  evt_vec,
  output logic              evt_any
);

  logic [2*NBITS-1:0] code_flat;
  logic [NBITS-1:0]   ena_q;
  logic               idx_ok;
  logic [NBITS-1:0]   prev_q;
  logic [NBITS-1:0]   hit;

  edge_cfg_bank #(.NBITS(NBITS), .IDXW(IDXW)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .idx_we      (cfg_idx_we),
    .idx         (cfg_idx),
    .val_we      (cfg_val_we),
    .val_is_mask (cfg_val_is_mask),
    .val         (cfg_val),
    .code_flat   (code_flat),
    .ena_q       (ena_q),
    .idx_ok      (idx_ok)
  );

  edge_readback #(.NBITS(NBITS), .RSW(RSW)) u_rd (
    .code_flat  (code_flat),
    .ena_q      (ena_q),
    .rd_sel     (rd_sel),
    .rd_is_mask (rd_is_mask),
    .rd_word    (rd_word)
  );

  edge_lane_array #(.NBITS(NBITS)) u_lanes (
    .code_flat (code_flat),
    .ena_q     (ena_q),
    .prev_q    (prev_q),
    .cur       (mon_data),
    .hit       (hit)
  );

  edge_sample_reg #(.NBITS(NBITS)) u_smp (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid  (mon_valid),
    .data   (mon_data),
    .hit    (hit),
    .prev_q (prev_q),
    .evt_q  (evt_vec)
  );

  assign evt_any = |evt_vec;

endmodule

// File: rtl/bitwise_edge_monitor_chk.sv
module bitwise_edge_monitor_chk #(
  parameter int NBITS = 256,
  parameter int IDXW  = $clog2(NBITS) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NBITS-1:0]   mon_data,
  input logic               mon_valid,
  input logic               cfg_idx_we,
  input logic [IDXW-1:0]    cfg_idx,
  input logic               cfg_val_we,
  input logic [NBITS-1:0]   evt_vec,
  input logic [2*NBITS-1:0] code_flat,
  input logic [NBITS-1:0]   ena_q,
  input logic               idx_ok
);

  logic past_ok, seen_valid;
  logic [NBITS-1:0] rise_v, fall_v, off_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok    <= 1'b0;
      seen_valid <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (mon_valid) seen_valid <= 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NBITS; i++) begin
      rise_v[i] = (code_flat[2*i +: 2] == 2'b00);
      fall_v[i] = (code_flat[2*i +: 2] == 2'b01);
      off_v[i]  = (code_flat[2*i +: 2] == 2'b11);
    end
  end

  a_r1_rise_ends_high: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((evt_vec & $past(rise_v) & ~$past(mon_data)) == '0));

  a_r2_fall_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((evt_vec & $past(fall_v) & $past(mon_data)) == '0));

  a_r4_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((evt_vec & $past(off_v)) == '0));

  a_r5_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((evt_vec & ~$past(ena_q)) == '0));

  a_r6_idle_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(mon_valid)) |-> (evt_vec == '0));

  a_r7_first_sample_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mon_valid) && !$past(seen_valid)) |-> (evt_vec == '0));

  a_r10_bad_index_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_idx_we && (cfg_idx >= IDXW'(NBITS))) |=> !idx_ok);

  a_r10_value_discarded: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_val_we && !cfg_idx_we && !idx_ok) |=> ($stable(ena_q) && $stable(code_flat)));

endmodule

bind bitwise_edge_monitor bitwise_edge_monitor_chk #(.NBITS(NBITS), .IDXW(IDXW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mon_data   (mon_data),
  .mon_valid  (mon_valid),
  .cfg_idx_we (cfg_idx_we),
  .cfg_idx    (cfg_idx),
  .cfg_val_we (cfg_val_we),
  .evt_vec    (evt_vec),
  .code_flat  (code_flat),
  .ena_q      (ena_q),
  .idx_ok     (idx_ok)
);

// File: tb/bitwise_edge_monitor_test.sv
module bitwise_edge_monitor_test;

  localparam int NBITS = 256;
  localparam int IDXW  = 9;
  localparam int RSW   = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NBITS-1:0] mon_data;
  logic             mon_valid;
  logic             cfg_idx_we;
  logic [IDXW-1:0]  cfg_idx;
  logic             cfg_val_we;
  logic             cfg_val_is_mask;
  logic [1:0]       cfg_val;
  logic [RSW-1:0]   rd_sel;
  logic             rd_is_mask;
  logic [31:0]      rd_word;
  logic [NBITS-1:0] evt_vec;
  logic             evt_any;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model built from the requirements
  logic [1:0]       m_code [NBITS];
  logic             m_ena  [NBITS];
  logic [NBITS-1:0] m_prev;
  bit               m_primed;
  int               m_idx;
  bit               m_ok;

  always #4 clk = ~clk;

  bitwise_edge_monitor #(.NBITS(NBITS), .IDXW(IDXW), .RSW(RSW)) uut (
    .clk(clk), .rst_n(rst_n), .mon_data(mon_data), .mon_valid(mon_valid),
    .cfg_idx_we(cfg_idx_we), .cfg_idx(cfg_idx), .cfg_val_we(cfg_val_we),
    .cfg_val_is_mask(cfg_val_is_mask), .cfg_val(cfg_val), .rd_sel(rd_sel),
    .rd_is_mask(rd_is_mask), .rd_word(rd_word), .evt_vec(evt_vec), .evt_any(evt_any)
  );

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_word(input string tag, input logic [NBITS-1:0] act, input logic [NBITS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NBITS-1:0] model_events(input logic [NBITS-1:0] d);
    logic [NBITS-1:0] e = '0;
    for (int i = 0; i < NBITS; i++) begin
      case (m_code[i])
        2'b00: e[i] = ~m_prev[i] & d[i];
        2'b01: e[i] = m_prev[i] & ~d[i];
        2'b10: e[i] = m_prev[i] ^ d[i];
        default: e[i] = 1'b0;
      endcase
      e[i] = e[i] & m_ena[i];
    end
    return e;
  endfunction

  // apply one sample at a falling edge, then check the registered result
  task automatic step(input string tag, input logic [NBITS-1:0] d, input logic v);
    logic [NBITS-1:0] exp;
    exp = (v && m_primed) ? model_events(d) : '0;
    mon_data  = d;
    mon_valid = v;
    @(negedge clk);
    mon_valid = 1'b0;
    if (v) begin
      m_prev   = d;
      m_primed = 1;
    end
    check_word({tag, " evt_vec"}, evt_vec, exp);
    check_bit({tag, " evt_any R8"}, evt_any, |exp);
  endtask

  task automatic wr_idx(input int i);
    cfg_idx_we = 1'b1;
    cfg_idx    = IDXW'(i);
    @(negedge clk);
    cfg_idx_we = 1'b0;
    if (i < NBITS) begin
      m_idx = i;
      m_ok  = 1;
    end else begin
      m_ok  = 0;
    end
  endtask

  task automatic wr_val(input bit is_mask, input logic [1:0] v);
    cfg_val_we      = 1'b1;
    cfg_val_is_mask = is_mask;
    cfg_val         = v;
    @(negedge clk);
    cfg_val_we = 1'b0;
    if (m_ok) begin
      if (is_mask) m_ena[m_idx] = v[0];
      else         m_code[m_idx] = v;
    end
  endtask

  task automatic check_readback(input string tag);
    for (int w = 0; w < 16; w++) begin
      logic [31:0] exp = '0;
      for (int k = 0; k < 16; k++) exp[2*k +: 2] = m_code[16*w + k];
      rd_is_mask = 1'b0;
      rd_sel = RSW'(w);
      #1;
      check_word({tag, " code word R11"}, NBITS'(rd_word), NBITS'(exp));
    end
    for (int w = 0; w < 16; w++) begin
      logic [31:0] exp = '0;
      if (w < 8) for (int k = 0; k < 32; k++) exp[k] = m_ena[32*w + k];
      rd_is_mask = 1'b1;
      rd_sel = RSW'(w);
      #1;
      check_word({tag, " enable word R11"}, NBITS'(rd_word), NBITS'(exp));
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    mon_data = '0; mon_valid = 0; cfg_idx_we = 0; cfg_idx = '0;
    cfg_val_we = 0; cfg_val_is_mask = 0; cfg_val = '0; rd_sel = '0; rd_is_mask = 0;
    for (int i = 0; i < NBITS; i++) begin m_code[i] = 2'b00; m_ena[i] = 1'b0; end
    m_prev = '0; m_primed = 0; m_ok = 0; m_idx = 0;
    repeat (3) @(negedge clk);
    check_word("reset evt_vec R12", evt_vec, '0);
    check_bit("reset evt_any R12", evt_any, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_word("after reset evt_vec R12", evt_vec, '0);
    check_readback("reset defaults R5");
  endtask

  task automatic t_program;
    for (int i = 0; i < NBITS; i++) begin
      wr_idx(i);
      wr_val(1'b0, 2'(i % 4));
      wr_val(1'b1, {1'b0, (i % 7) != 6});
    end
    check_readback("indexed programming R9");
  endtask

  task automatic t_first_sample;
    step("first valid sample R7", {NBITS{1'b1}}, 1'b1);
  endtask

  task automatic t_patterns;
    step("all fall R2 R3", '0, 1'b1);
    step("all rise R1 R3", {NBITS{1'b1}}, 1'b1);
    step("checker pattern R1 R2 R3 R4", {8{32'hA5A5_0F0F}}, 1'b1);
    step("inverted pattern R1 R2 R3 R4", {8{32'h5A5A_F0F0}}, 1'b1);
    step("no change R8", {8{32'h5A5A_F0F0}}, 1'b1);
    step("mixed pattern", {8{32'h1234_8765}}, 1'b1);
  endtask

  task automatic t_single_bits;
    step("clear R1", '0, 1'b1);
    step("bit0 rise R1", NBITS'(1), 1'b1);
    check_bit("bit0 rising code R1", evt_vec[0], 1'b1);
    step("bit1 rise ignored by falling code R2", NBITS'(3), 1'b1);
    check_bit("bit1 no event on rise R2", evt_vec[1], 1'b0);
    step("bit1 fall R2", NBITS'(1), 1'b1);
    check_bit("bit1 falling code R2", evt_vec[1], 1'b1);
    step("bit2 rise R3", NBITS'(5), 1'b1);
    check_bit("bit2 toggle rise R3", evt_vec[2], 1'b1);
    step("bit2 fall R3", NBITS'(1), 1'b1);
    check_bit("bit2 toggle fall R3", evt_vec[2], 1'b1);
    step("bit3 rise R4", NBITS'(9), 1'b1);
    check_bit("bit3 reserved R4", evt_vec[3], 1'b0);
    step("bit6 disabled toggle R5", NBITS'(9) | NBITS'(64), 1'b1);
    check_bit("bit6 disabled R5", evt_vec[6], 1'b0);
    step("bit0 held high one cycle R8", NBITS'(9) | NBITS'(64), 1'b1);
    check_bit("bit0 event gone R8", evt_vec[0], 1'b0);
  endtask

  task automatic t_idle;
    step("idle changed data R6", {NBITS{1'b1}}, 1'b0);
    step("idle again R6", '0, 1'b0);
    step("resume same sample R6", NBITS'(9) | NBITS'(64), 1'b1);
    check_bit("no event after gap R6", evt_any, 1'b0);
  endtask

  task automatic t_bad_index;
    wr_idx(5);
    wr_idx(256);
    wr_val(1'b1, 2'b00);
    wr_val(1'b0, 2'b11);
    check_readback("index 256 discards R10");
    wr_idx(40);
    wr_idx(511);
    wr_val(1'b0, 2'b11);
    check_readback("index 511 discards R10");
    wr_idx(40);
    wr_val(1'b0, 2'b11);
    check_readback("valid index restores writes R9 R10");
  endtask

  initial begin
    t_reset();
    t_program();
    t_first_sample();
    t_patterns();
    t_single_bits();
    t_idle();
    t_bad_index();
    step("after reconfig R4", '0, 1'b1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule